// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Address Filtering

This block receives asynchronous serial frames of eleven bit periods. Each frame is a low start bit, eight data bits with the least significant bit first, a ninth bit, and a high stop bit. The line is sampled on a 16x oversampling enable. Each bit value is the two-of-three vote of the samples taken at ticks 7, 8 and 9 of the bit period, counted from the tick at which the start edge was seen (tick 0).

Multiprocessor mode lets one station on a shared line ignore traffic meant for other stations. When the mode is on, a frame is delivered only if its ninth bit is 1 and its byte is accepted by one of two filters. The first filter compares the byte with the station address, but only in the bit positions where the mask is 1. The second filter is a broadcast address formed as the OR of the station address and the mask. It accepts any byte that has a 1 in every position where that OR has a 1. When the mode is off, every frame with a good stop bit is delivered.

A sticky framing-error flag and a general mode bit share one status position. A select input chooses which of the two that position reads and writes. The station address and mask arrive as inputs from registers outside the block, and those registers reset to 00h.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, rx_ready, frame_err, mode_hi, rx_data and rx_bit9 are all 0.
- R2: A frame of start 0, data bits d0..d7, ninth bit, and stop 1, each bit lasting 16 oversampling ticks, yields rx_data = d7..d0 and rx_bit9 = the ninth bit. A single wrong sample within ticks 7 to 9 of a bit does not change that bit.
- R3: A low pulse on the line that has ended before tick 7 of a start bit is ignored. The receiver returns to idle, and rx_ready, rx_data, rx_bit9 and frame_err are unchanged.
- R4: With mp_en = 0, every frame with a valid stop bit sets rx_ready and loads rx_data and rx_bit9, whatever its ninth bit and byte.
- R5: With mp_en = 1, a frame whose ninth bit is 0 is dropped. rx_ready, rx_data and rx_bit9 keep their values.
- R6: With mp_en = 1 and ninth bit 1, a byte is accepted when ((byte XOR own_addr) AND addr_mask) = 0. Mask bits set to 0 are don't-care.
- R7: With mp_en = 1 and ninth bit 1, a byte is accepted when (byte AND B) = B, where B = own_addr OR addr_mask.
- R8: With mp_en = 1, a frame with ninth bit 1 whose byte meets neither R6 nor R7 is dropped with no change to rx_ready, rx_data or rx_bit9.
- R9: A stop bit voted 0 sets frame_err and drops the frame. rx_ready, rx_data and rx_bit9 are unchanged.
- R10: frame_err stays set through later valid frames. It changes only through a write with fe_sel = 1, which loads top_wdata into it.
- R11: top_rdata shows frame_err when fe_sel = 1 and mode_hi when fe_sel = 0. A write with fe_sel = 0 loads top_wdata into mode_hi and leaves frame_err unchanged.
- R12: rx_ready stays set until a one-cycle pulse on rdy_clr clears it. If rdy_clr and a newly delivered frame fall in the same cycle, the frame wins and rx_ready stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| own_addr | input | 8 | Station address |
| addr_mask | input | 8 | Address mask, 0 marks a don't-care bit |
| fe_sel | input | 1 | Selects frame_err (1) or mode_hi (0) for the shared status bit |
| top_wr | input | 1 | Write strobe for the shared status bit |
| top_wdata | input | 1 | Value written to the shared status bit |
| top_rdata | output | 1 | Read value of the shared status bit |
| rdy_clr | input | 1 | Clears rx_ready |
| rx_data | output | 8 | Last delivered byte |
| rx_bit9 | output | 1 | Ninth bit of the last delivered frame |
| rx_ready | output | 1 | Receive-complete flag |
| frame_err | output | 1 | Sticky framing-error flag |
| mode_hi | output | 1 | Mode bit that shares the status position |

## Verification
The random frames are weighted so that many bytes hit the station address, the broadcast pattern, or either one with don't-care bits flipped. A filter that compared masked-out bits, or that built the broadcast address the wrong way round, would deliver or drop the wrong frames. Directed cases cover the following faults:
- A half-width start glitch. A design that skips the mid-bit start check would read a phantom frame.
- A single flipped sample in the voting window. A design that samples only one point would corrupt the data.
- A bad stop bit followed by a good frame. A design without the sticky flag would lose the error.
- Writes to the shared bit under both select values. A design with the wrong steering would corrupt the other flag.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
    endfunction
endpackage

// File: rtl/mprx_sampler.sv
module mprx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic rxd,
    output logic line_s,
    output logic vote
);
    import mprx_pkg::*;

    typedef struct packed {
        logic [1:0] sync;
        logic [1:0] win;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.sync = {smp_q.sync[0], rxd};
        if (os_tick) begin
            smp_d.win = {smp_q.win[0], smp_q.sync[1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign line_s = smp_q.sync[1];
    assign vote   = vote3({smp_q.win, smp_q.sync[1]});
endmodule

// File: rtl/mprx_addr_match.sv
module mprx_addr_match #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] addr_mask,
    output logic              hit
);
    logic [ADDR_W-1:0] bcast;
    logic              given_hit;
    logic              bcast_hit;

    always_comb begin
        bcast     = own_addr | addr_mask;
        given_hit = ((rx_byte ^ own_addr) & addr_mask) == '0;
        bcast_hit = (rx_byte & bcast) == bcast;
        hit       = given_hit | bcast_hit;
    end
endmodule

// File: rtl/mprx_status.sv
module mprx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic fe_set,
    input  logic wr,
    input  logic sel,
    input  logic wdata,
    output logic fe,
    output logic mode,
    output logic rdata
);
    typedef struct packed {
        logic fe;
        logic mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && sel)  st_d.fe   = wdata;
        if (wr && !sel) st_d.mode = wdata;
        if (fe_set)     st_d.fe   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fe    = st_q.fe;
    assign mode  = st_q.mode;
    assign rdata = sel ? st_q.fe : st_q.mode;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              fe_sel,
    input  logic              top_wr,
    input  logic              top_wdata,
    output logic              top_rdata,
    input  logic              rdy_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ready,
    output logic              frame_err,
    output logic              mode_hi
);
    import mprx_pkg::*;

    localparam int CNT_W  = $clog2(OS_RATE);
    localparam int BIT_W  = $clog2(DATA_W + 1);
    localparam int DECIDE = OS_RATE / 2 + 1;
    localparam int LAST   = OS_RATE - 1;

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DATA_W:0]   shreg;
        logic [DATA_W-1:0] data;
        logic              b9;
        logic              ready;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic line_s, vote, addr_hit, pass;
    logic accept, fe_set;

    mprx_sampler u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .os_tick(os_tick),
        .rxd    (rxd),
        .line_s (line_s),
        .vote   (vote)
    );

    mprx_addr_match #(.ADDR_W(DATA_W)) u_match (
        .rx_byte  (rx_q.shreg[DATA_W-1:0]),
        .own_addr (own_addr),
        .addr_mask(addr_mask),
        .hit      (addr_hit)
    );

    mprx_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .fe_set(fe_set),
        .wr    (top_wr),
        .sel   (fe_sel),
        .wdata (top_wdata),
        .fe    (frame_err),
        .mode  (mode_hi),
        .rdata (top_rdata)
    );

    assign pass = !mp_en || (rx_q.shreg[DATA_W] && addr_hit);

    always_comb begin
        rx_d   = rx_q;
        accept = 1'b0;
        fe_set = 1'b0;
        if (rdy_clr) rx_d.ready = 1'b0;
        if (os_tick) begin
            if (rx_q.state == ST_IDLE) begin
                if (!line_s) begin
                    rx_d.state = ST_START;
                    rx_d.cnt   = CNT_W'(1);
                end
            end else begin
                rx_d.cnt = (rx_q.cnt == CNT_W'(LAST)) ? '0 : rx_q.cnt + 1'b1;
                if (rx_q.cnt == CNT_W'(DECIDE)) begin
                    case (rx_q.state)
                        ST_START: begin
                            if (vote) begin
                                rx_d.state = ST_IDLE;
                            end else begin
                                rx_d.state = ST_BITS;
                                rx_d.bitn  = '0;
                            end
                        end
                        ST_BITS: begin
                            rx_d.shreg = {vote, rx_q.shreg[DATA_W:1]};
                            if (rx_q.bitn == BIT_W'(DATA_W)) rx_d.state = ST_STOP;
                            else                              rx_d.bitn  = rx_q.bitn + 1'b1;
                        end
                        ST_STOP: begin
                            rx_d.state = ST_IDLE;
                            if (!vote)     fe_set = 1'b1;
                            else if (pass) accept = 1'b1;
                        end
                        default: rx_d.state = ST_IDLE;
                    endcase
                end
            end
        end
        if (accept) begin
            rx_d.data  = rx_q.shreg[DATA_W-1:0];
            rx_d.b9    = rx_q.shreg[DATA_W];
            rx_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '{state: ST_IDLE, default: '0};
        else        rx_q <= rx_d;
    end

    assign rx_data  = rx_q.data;
    assign rx_bit9  = rx_q.b9;
    assign rx_ready = rx_q.ready;
endmodule

// File: rtl/mprx_checker.sv
module mprx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mp_en,
    input logic              top_wr,
    input logic              fe_sel,
    input logic              accept,
    input logic              fe_set,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              frame_err,
    input logic              mode_hi
);
    AST_MP_NEEDS_BIT9: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mp_en |=> rx_bit9); // R5
    AST_BADSTOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        fe_set |=> frame_err); // R9
    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err && !(top_wr && fe_sel) |=> frame_err); // R10
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(top_wr && !fe_sel) |=> $stable(mode_hi)); // R11
    AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rx_ready); // R12
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(rx_data) && $stable(rx_bit9)); // R8
endmodule

bind mp_uart_rx mprx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mp_en    (mp_en),
    .top_wr   (top_wr),
    .fe_sel   (fe_sel),
    .accept   (accept),
    .fe_set   (fe_set),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_bit9  (rx_bit9),
    .frame_err(frame_err),
    .mode_hi  (mode_hi)
);

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;
    localparam int BITCLK = 32; // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       mp_en = 1'b0;
    logic [7:0] own_addr = '0;
    logic [7:0] addr_mask = '0;
    logic       fe_sel = 1'b0;
    logic       top_wr = 1'b0;
    logic       top_wdata = 1'b0;
    logic       top_rdata;
    logic       rdy_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ready, frame_err, mode_hi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_data = '0;
    logic       m_b9 = 0, m_rdy = 0, m_fe = 0, m_mode = 0;

    mp_uart_rx u_mp_uart_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .mp_en(mp_en), .own_addr(own_addr), .addr_mask(addr_mask),
        .fe_sel(fe_sel), .top_wr(top_wr), .top_wdata(top_wdata),
        .top_rdata(top_rdata), .rdy_clr(rdy_clr), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .frame_err(frame_err),
        .mode_hi(mode_hi)
    );

    always #10 clk = ~clk;

    initial forever @(negedge clk) os_tick <= ~os_tick;

    function automatic bit exp_accept(bit mp, logic [7:0] d, bit b9,
                                      logic [7:0] own, logic [7:0] msk);
        logic [7:0] b;
        b = own | msk;
        if (!mp) return 1'b1;
        if (!b9) return 1'b0;
        return (((d ^ own) & msk) == 8'h00) || ((d & b) == b);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk({tag, " rx_ready"}, int'(rx_ready), int'(m_rdy));
        chk({tag, " rx_data"}, int'(rx_data), int'(m_data));
        chk({tag, " rx_bit9"}, int'(rx_bit9), int'(m_b9));
        chk({tag, " frame_err"}, int'(frame_err), int'(m_fe));
    endtask

    task automatic wait_bits(int n);
        repeat (n * BITCLK) @(negedge clk);
    endtask

    task automatic send(logic [7:0] d, bit b9, bit stop_ok, int glitch_bit);
        logic [10:0] f;
        f = {stop_ok, b9, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            for (int c = 0; c < BITCLK; c++) begin
                @(negedge clk);
                rxd <= (i == glitch_bit && (c == 16 || c == 17)) ? ~f[i] : f[i];
            end
        end
        @(negedge clk);
        rxd <= 1'b1;
        wait_bits(2);
        if (!stop_ok) m_fe = 1'b1;
        else if (exp_accept(mp_en, d, b9, own_addr, addr_mask)) begin
            m_data = d; m_b9 = b9; m_rdy = 1'b1;
        end
    endtask

    task automatic clear_ready();
        @(negedge clk); rdy_clr <= 1'b1;
        @(negedge clk); rdy_clr <= 1'b0;
        m_rdy = 1'b0;
    endtask

    task automatic wr_bit(bit sel, bit v);
        @(negedge clk); fe_sel <= sel; top_wr <= 1'b1; top_wdata <= v;
        @(negedge clk); top_wr <= 1'b0;
        if (sel) m_fe = v; else m_mode = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (5) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        chk_all("R1 reset");
        chk("R1 mode_hi", int'(mode_hi), 0);

        // R2: plain frame, then glitch in one voting sample
        send(8'hA5, 1'b1, 1'b1, -1);
        chk_all("R2 basic");
        clear_ready();
        chk("R12 cleared", int'(rx_ready), 0);
        send(8'h3C, 1'b0, 1'b1, 4);
        chk_all("R2 glitch");

        // R3: short low pulse
        @(negedge clk); rxd <= 1'b0;
        repeat (6) @(negedge clk);
        rxd <= 1'b1;
        wait_bits(3);
        chk_all("R3 false start");

        // R4: mp_en off, ninth bit 0, unrelated byte
        own_addr <= 8'h12; addr_mask <= 8'hFF;
        clear_ready();
        send(8'h77, 1'b0, 1'b1, -1);
        chk_all("R4 mp off");

        // R5 / R6 / R7 / R8 directed
        mp_en <= 1'b1;
        own_addr <= 8'b1010_0000; addr_mask <= 8'b1111_0000;
        clear_ready();
        send(8'b1010_0110, 1'b0, 1'b1, -1);
        chk_all("R5 bit9 zero");
        send(8'b1010_0110, 1'b1, 1'b1, -1);
        chk_all("R6 given match dont-care");
        clear_ready();
        send(8'b1111_0001, 1'b1, 1'b1, -1);
        chk_all("R7 broadcast");
        clear_ready();
        send(8'b0110_0000, 1'b1, 1'b1, -1);
        chk_all("R8 no match");
        chk("R8 ready low", int'(rx_ready), 0);

        // R9 / R10: bad stop, sticky through good frame
        send(8'hF0, 1'b1, 1'b0, -1);
        chk_all("R9 bad stop");
        send(8'hF0, 1'b1, 1'b1, -1);
        chk_all("R10 sticky");
        fe_sel <= 1'b1;
        @(negedge clk);
        chk("R11 read fe", int'(top_rdata), int'(m_fe));

        // R11: mode write does not touch fe
        wr_bit(1'b0, 1'b1);
        @(negedge clk);
        chk("R11 mode_hi", int'(mode_hi), int'(m_mode));
        chk("R11 fe kept", int'(frame_err), int'(m_fe));
        chk("R11 read mode", int'(top_rdata), int'(m_mode));
        wr_bit(1'b1, 1'b0);
        @(negedge clk);
        chk("R10 fe cleared", int'(frame_err), 0);
        chk("R11 mode kept", int'(mode_hi), int'(m_mode));

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            int sel;
            mp_en     <= 1'($urandom_range(0, 3) != 0);
            own_addr  <= 8'($urandom);
            addr_mask <= 8'($urandom);
            @(negedge clk);
            sel = $urandom_range(0, 3);
            case (sel)
                0: d = own_addr ^ (~addr_mask & 8'($urandom));
                1: d = (own_addr | addr_mask) | 8'($urandom);
                2: d = own_addr;
                default: d = 8'($urandom);
            endcase
            if ($urandom_range(0, 2) == 0) clear_ready();
            send(d, 1'($urandom), 1'($urandom_range(0, 7) != 0), -1);
            chk_all("R6 R7 R8 random");
            if (m_fe) wr_bit(1'b1, 1'b0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule